// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst into a synchronous SRAM. When a burst begins, it captures the whole address. On later clock edges, it moves the two least significant address bits through one of two beat orders. The upper address bits pass through unchanged. Read bursts and write bursts use the same sequencer.

A static order-select input picks the beat order:
- **Linear order** adds the beat number to the captured start value, modulo 4.
- **Interleaved order** XORs the beat number into the start value.

The step input is active low. A load on the same edge as a step wins over the step. With no load and no step, the address holds.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after reset until the first load, `addr_out` is all zeros.
- R2: On a rising edge with `load` high, `addr_out` becomes equal to `ld_addr`. This is beat 0 of a new burst, and it holds in either order.
- R3: Bits `[AW-1:2]` of `addr_out` change only on an edge with `load` high. A step never alters them.
- R4: With `interleave` low (linear order), each edge with `step_n` low and `load` low sets `addr_out[1:0]` to the start value plus the number of steps since the load, modulo 4. For start 01 the sequence is 01, 10, 11, 00.
- R5: With `interleave` high (interleaved order), each edge with `step_n` low and `load` low sets `addr_out[1:0]` to the start value XOR the number of steps since the load. For start 01 the sequence is 01, 00, 11, 10. For start 10 it is 10, 11, 00, 01.
- R6: In either order, the fourth step after a load wraps `addr_out[1:0]` back to the start value.
- R7: An edge with `load` low and `step_n` high leaves `addr_out` unchanged.
- R8: When `load` is high and `step_n` is low on the same edge, the load wins. `addr_out` equals `ld_addr` and the beat count restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Begin a burst: capture `ld_addr` and clear the beat count |
| ld_addr | input | AW | Burst start address |
| step_n | input | 1 | Active-low advance to the next beat |
| interleave | input | 1 | Beat order: 1 = interleaved (XOR), 0 = linear (add) |
| addr_out | output | AW | Address of the current beat |

## Verification
A burst start and a beat advance can fall on the same clock edge. The bench provokes this in two ways:
- It raises `load` while `step_n` is low in the middle of a running burst.
- It does the same thing as the very first action after reset.

The result is judged correct only if `addr_out` equals the new `ld_addr` exactly. The following step must then produce beat 1 of the new start value, which shows that the beat count restarted rather than carrying over from the interrupted burst.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic          step_n,
  input  logic          interleave,
  output logic [AW-1:0] addr_out
);
  localparam int UW = AW - 2;

  logic [UW-1:0] upper_q;
  logic [1:0]    start_q;
  logic [1:0]    beat_q;
  logic [1:0]    low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      upper_q <= ld_addr[AW-1:2];
      start_q <= ld_addr[1:0];
      beat_q  <= '0;
    end else if (!step_n) begin
      beat_q  <= beat_q + 2'd1;
    end
  end

  assign low      = interleave ? (start_q ^ beat_q) : (start_q + beat_q);
  assign addr_out = {upper_q, low};

  a_r2_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_out == $past(ld_addr)));

  a_r8_load_beats_step: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !step_n) |=> (addr_out[1:0] == $past(ld_addr[1:0])));

  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(addr_out[AW-1:2]));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step_n) |=> ($stable(addr_out) || !$stable(interleave)));

  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_n && !interleave) |=>
      (interleave || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));
endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic          step_n = 1'b1;
  logic          interleave = 1'b0;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(ld_addr),
    .step_n(step_n), .interleave(interleave), .addr_out(addr_out)
  );

  task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic ld, input logic [AW-1:0] a, input logic sn);
    @(negedge clk);
    load = ld; ld_addr = a; step_n = sn;
    @(posedge clk); #1;
    load = 1'b0; step_n = 1'b1;
  endtask

  function automatic logic [1:0] beat(input logic il, input logic [1:0] s, input int k);
    logic [1:0] kk;
    kk = 2'(k);
    return il ? (s ^ kk) : (s + kk);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    cyc(1'b0, '0, 1'b0);
    chk("R1 during reset", addr_out, '0);
    @(negedge clk); rst_n = 1'b1;
    cyc(1'b0, '0, 1'b1);
    chk("R1 after reset", addr_out, '0);
  endtask

  task automatic t_order(input logic il, input string req);
    interleave = il;
    for (int s = 0; s < 4; s++) begin
      logic [AW-1:0] a;
      a = {18'h2B6C1 + 18'(s * 17), 2'(s)};
      cyc(1'b1, a, 1'b1);
      chk("R2 load", addr_out, a);
      for (int k = 1; k <= 4; k++) begin
        cyc(1'b0, '0, 1'b0);
        chk(k == 4 ? "R6 wrap" : req, addr_out, {a[AW-1:2], beat(il, a[1:0], k)});
        chk("R3 upper bits", {addr_out[AW-1:2], 2'b00}, {a[AW-1:2], 2'b00});
      end
    end
  endtask

  task automatic t_hold();
    logic [AW-1:0] a;
    a = 20'h3F0E1;
    interleave = 1'b1;
    cyc(1'b1, a, 1'b1);
    cyc(1'b0, '0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, 20'hFFFFF, 1'b1);
      chk("R7 hold", addr_out, {a[AW-1:2], 2'b00});
    end
    cyc(1'b0, '0, 1'b0);
    chk("R5 after hold", addr_out, {a[AW-1:2], 2'b11});
  endtask

  task automatic t_priority();
    logic [AW-1:0] a, b;
    a = 20'h12342; b = 20'hABCD1;
    interleave = 1'b0;
    cyc(1'b1, a, 1'b1);
    cyc(1'b0, '0, 1'b0);
    cyc(1'b0, '0, 1'b0);
    cyc(1'b1, b, 1'b0);
    chk("R8 load wins", addr_out, b);
    cyc(1'b0, '0, 1'b0);
    chk("R8 count restarted", addr_out, {b[AW-1:2], 2'b10});
    rst_n = 1'b0;
    cyc(1'b0, '0, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    interleave = 1'b1;
    cyc(1'b1, b, 1'b0);
    chk("R8 first after reset", addr_out, b);
    cyc(1'b0, '0, 1'b0);
    chk("R8 interleaved beat 1", addr_out, {b[AW-1:2], 2'b00});
  endtask

  initial begin
    t_reset();
    t_order(1'b0, "R4 linear");
    t_order(1'b1, "R5 interleaved");
    t_hold();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule